// File: doc/BRIEF.md
# VRAM Fill, Copy and External Transfer DMA Engine

This engine carries out the bulk memory operations of a video controller. Its own small register window holds a 16-bit unit count and a 24-bit source/mode word. When the controller accepts an address command that has the DMA flag set, it pulses `start` and supplies the destination address and the target memory. The engine then runs one of three operations. Fill waits for a data-port write and repeats that word into consecutive destination units. Copy moves bytes inside VRAM. External transfer fetches 16-bit words over a host bus and stores them in the selected memory (VRAM, colour RAM or vertical-scroll RAM).

While an operation is running, the engine raises `busy`, holds its register window against writes, and uses the unit count and source address as live counters. As a result, software reading back the window after completion sees the count at zero and the source pointing just past the last unit. The engine owns only the sequencing and the request side of the host bus. The bus arbiter and the memories sit outside it.

Top module: `vram_dma_engine`

## Requirements
- R1: After reset, `busy`, `mem_we`, `vr_re` and `hb_req` are low, and `cnt_q` and `src_q` read zero.
- R2: Register writes with `reg_idx` 19 and 20 load `cnt_q[7:0]` and `cnt_q[15:8]`. Indices 21, 22 and 23 load `src_q[7:0]`, `src_q[15:8]` and `src_q[23:16]`. At `start`, `src_q[23:22]` selects the mode: 2'b10 is fill and 2'b11 is copy. Any value with bit 23 at 0 is an external transfer, and bit 22 then counts as an address bit, not a mode bit.
- R3: In fill mode, no memory write happens until a `data_we` pulse. After it, each unit is a byte write (`mem_byte`=1) to the target given at `start`, and `mem_wdata` equals the captured `data_in` word.
- R4: In copy mode, each unit reads VRAM at byte address `src_q[15:0]` with `vr_re`, takes `vr_rdata` one cycle later, and writes it as a byte to VRAM (`mem_sel`=0) on both halves of `mem_wdata`, whatever `start_sel` was. The source then steps by 1.
- R5: In external mode, `hb_req` rises with `hb_addr` = `src_q[22:0]` and stays high until `hb_ack`. The `hb_data` word taken at the ack is written as a word (`mem_byte`=0) to the target given at `start`.
- R6: In external mode, the source word address advances in its low 17 bits only: 0x1FFFF wraps to 0x00000, and `src_q[23:17]` does not change.
- R7: The first unit goes to `start_addr`. Each later unit goes to the previous address plus `auto_inc`, modulo 2^16.
- R8: A count of N performs exactly N units, and a count of zero performs 65536 units.
- R9: `busy` is high from the cycle after `start` through the cycle of the last memory write, including the wait for fill data, and is low in the following cycle.
- R10: After completion, `cnt_q` reads zero and `src_q` holds the source advanced by the number of units moved (unchanged for fill).
- R11: Register writes while `busy` is high do not change `cnt_q` or `src_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register window write strobe |
| reg_idx | input | 5 | Register index (19 to 23 used) |
| reg_wdata | input | 8 | Register write byte |
| start | input | 1 | Address command with DMA flag accepted |
| start_sel | input | 2 | Target memory: 0 VRAM, 1 colour RAM, 2 scroll RAM |
| start_addr | input | 16 | Destination start address |
| auto_inc | input | 8 | Destination step per unit |
| data_we | input | 1 | Data-port write strobe |
| data_in | input | 16 | Data-port word |
| busy | output | 1 | Operation in progress |
| cnt_q | output | 16 | Remaining unit count readback |
| src_q | output | 24 | Source/mode word readback |
| vr_re | output | 1 | VRAM byte read strobe (copy) |
| vr_addr | output | 16 | VRAM read byte address |
| vr_rdata | input | 8 | VRAM read byte, valid the cycle after `vr_re` |
| hb_req | output | 1 | Host bus fetch request |
| hb_addr | output | 23 | Host bus word address |
| hb_ack | input | 1 | Host bus acknowledge with data |
| hb_data | input | 16 | Host bus read word |
| mem_we | output | 1 | Memory write strobe |
| mem_sel | output | 2 | Target memory of the write |
| mem_addr | output | 16 | Write address |
| mem_wdata | output | 16 | Write data |
| mem_byte | output | 1 | 1 for a byte unit, 0 for a word unit |

## Verification
Two situations are hard to reach from the ports. The first is the 17-bit wrap of an external source, which only shows in the middle of a transfer. The stimulus places the source at 0x47FFFE, so the third fetch must come from 0x460000 with the upper bits and the mode bit 22 left as they were. The bench model returns data derived from the address, so a wrong fetch address appears as wrong written data. The second is the zero-count case, which needs a full 65536-unit fill. The bench queues every expected write and checks that the queue drains exactly when `busy` falls. Register writes issued during the fill-data wait then confirm that the window is frozen.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL_WAIT,
    S_FILL_WR,
    S_CPY_RD,
    S_CPY_WR,
    S_EXT_REQ,
    S_EXT_WR
  } seq_state_e;

  typedef enum logic [1:0] {
    M_EXT,
    M_FILL,
    M_COPY
  } dma_mode_e;

  function automatic dma_mode_e decode_mode(logic [1:0] top_bits);
    if (!top_bits[1])     return M_EXT;
    else if (top_bits[0]) return M_COPY;
    else                  return M_FILL;
  endfunction

endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int LEN_W   = 16,
  parameter int SRC_W   = 24,
  parameter int WRAP_W  = 17,
  parameter int CPY_W   = 16,
  parameter int IDX_LLO = 19,
  parameter int IDX_LHI = 20,
  parameter int IDX_SLO = 21,
  parameter int IDX_SMI = 22,
  parameter int IDX_SHI = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [7:0]       reg_wdata,
  input  logic             busy,
  input  logic             unit_done,
  output logic [LEN_W-1:0] cnt_q,
  output logic [SRC_W-1:0] src_q,
  output dma_mode_e        mode
);

  logic [LEN_W-1:0] cnt_n;
  logic [SRC_W-1:0] src_n;
  logic             upd_en;

  assign mode = decode_mode(src_q[SRC_W-1:SRC_W-2]);

  always_comb begin
    cnt_n  = cnt_q;
    src_n  = src_q;
    upd_en = 1'b0;
    if (unit_done) begin
      upd_en = 1'b1;
      cnt_n  = cnt_q - LEN_W'(1);
      if (mode == M_COPY)
        src_n[CPY_W-1:0] = src_q[CPY_W-1:0] + CPY_W'(1);
      else if (mode == M_EXT)
        src_n[WRAP_W-1:0] = src_q[WRAP_W-1:0] + WRAP_W'(1);
    end else if (reg_we && !busy) begin
      upd_en = 1'b1;
      if (reg_idx == IDX_W'(IDX_LLO))      cnt_n[7:0]   = reg_wdata;
      else if (reg_idx == IDX_W'(IDX_LHI)) cnt_n[15:8]  = reg_wdata;
      else if (reg_idx == IDX_W'(IDX_SLO)) src_n[7:0]   = reg_wdata;
      else if (reg_idx == IDX_W'(IDX_SMI)) src_n[15:8]  = reg_wdata;
      else if (reg_idx == IDX_W'(IDX_SHI)) src_n[23:16] = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_n;
      src_q <= src_n;
    end
  end

  AST_WRAP_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && mode == M_EXT) |=> $stable(src_q[SRC_W-1:WRAP_W])); // R6

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !unit_done) |=> ($stable(cnt_q) && $stable(src_q))); // R11

endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int HB_W   = 23,
  parameter int INC_W  = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  start_sel,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [INC_W-1:0]  auto_inc,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_in,
  input  dma_mode_e         mode,
  input  logic              last,
  input  logic [HB_W-1:0]   src,
  input  logic [DATA_W/2-1:0] vr_rdata,
  input  logic              hb_ack,
  input  logic [DATA_W-1:0] hb_data,
  output logic              busy,
  output logic              unit_done,
  output logic              vr_re,
  output logic [ADDR_W-1:0] vr_addr,
  output logic              hb_req,
  output logic [HB_W-1:0]   hb_addr,
  output logic              mem_we,
  output logic [SEL_W-1:0]  mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_byte
);

  seq_state_e        state_q, state_n;
  logic [ADDR_W-1:0] dst_q, dst_n;
  logic [SEL_W-1:0]  tgt_q, tgt_n;
  logic [DATA_W-1:0] hold_q, hold_n;
  logic [ADDR_W-1:0] dst_step;

  assign dst_step = dst_q + ADDR_W'(auto_inc);
  assign busy     = (state_q != S_IDLE);
  assign vr_addr  = src[ADDR_W-1:0];
  assign hb_addr  = src;
  assign mem_addr = dst_q;

  always_comb begin
    state_n   = state_q;
    dst_n     = dst_q;
    tgt_n     = tgt_q;
    hold_n    = hold_q;
    unit_done = 1'b0;
    vr_re     = 1'b0;
    hb_req    = 1'b0;
    mem_we    = 1'b0;
    mem_sel   = tgt_q;
    mem_wdata = hold_q;
    mem_byte  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          tgt_n = start_sel;
          dst_n = start_addr;
          case (mode)
            M_FILL:  state_n = S_FILL_WAIT;
            M_COPY:  state_n = S_CPY_RD;
            default: state_n = S_EXT_REQ;
          endcase
        end
      end
      S_FILL_WAIT: begin
        if (data_we) begin
          hold_n  = data_in;
          state_n = S_FILL_WR;
        end
      end
      S_FILL_WR: begin
        mem_we    = 1'b1;
        mem_byte  = 1'b1;
        unit_done = 1'b1;
        dst_n     = dst_step;
        if (last) state_n = S_IDLE;
      end
      S_CPY_RD: begin
        vr_re   = 1'b1;
        state_n = S_CPY_WR;
      end
      S_CPY_WR: begin
        mem_we    = 1'b1;
        mem_byte  = 1'b1;
        mem_sel   = '0;
        mem_wdata = {vr_rdata, vr_rdata};
        unit_done = 1'b1;
        dst_n     = dst_step;
        state_n   = last ? S_IDLE : S_CPY_RD;
      end
      S_EXT_REQ: begin
        hb_req = 1'b1;
        if (hb_ack) begin
          hold_n  = hb_data;
          state_n = S_EXT_WR;
        end
      end
      S_EXT_WR: begin
        mem_we    = 1'b1;
        unit_done = 1'b1;
        dst_n     = dst_step;
        state_n   = last ? S_IDLE : S_EXT_REQ;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dst_q   <= '0;
      tgt_q   <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_n;
      dst_q   <= dst_n;
      tgt_q   <= tgt_n;
      hold_q  <= hold_n;
    end
  end

  AST_ONE_PORT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, vr_re, hb_req})); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_req && !hb_ack) |=> hb_req); // R5

  AST_COPY_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    vr_re |=> (mem_we && mem_byte && mem_sel == '0)); // R4

  AST_FILL_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FILL_WAIT && !data_we) |=> !mem_we); // R3

endmodule

// File: rtl/vram_dma_engine.sv
module vram_dma_engine
  import vdma_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int LEN_W  = 16,
  parameter int SRC_W  = 24,
  parameter int WRAP_W = 17,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int INC_W  = 8,
  parameter int SEL_W  = 2,
  localparam int HB_W  = SRC_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [IDX_W-1:0]    reg_idx,
  input  logic [7:0]          reg_wdata,
  input  logic                start,
  input  logic [SEL_W-1:0]    start_sel,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [INC_W-1:0]    auto_inc,
  input  logic                data_we,
  input  logic [DATA_W-1:0]   data_in,
  output logic                busy,
  output logic [LEN_W-1:0]    cnt_q,
  output logic [SRC_W-1:0]    src_q,
  output logic                vr_re,
  output logic [ADDR_W-1:0]   vr_addr,
  input  logic [DATA_W/2-1:0] vr_rdata,
  output logic                hb_req,
  output logic [HB_W-1:0]     hb_addr,
  input  logic                hb_ack,
  input  logic [DATA_W-1:0]   hb_data,
  output logic                mem_we,
  output logic [SEL_W-1:0]    mem_sel,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_byte
);

  logic      rst_meta_q, rst_sync_q;
  logic      unit_done;
  logic      last;
  dma_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign last = (cnt_q == LEN_W'(1));

  vdma_regs #(
    .IDX_W(IDX_W), .LEN_W(LEN_W), .SRC_W(SRC_W), .WRAP_W(WRAP_W), .CPY_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_q),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .busy(busy), .unit_done(unit_done),
    .cnt_q(cnt_q), .src_q(src_q), .mode(mode)
  );

  vdma_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HB_W(HB_W), .INC_W(INC_W), .SEL_W(SEL_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_q),
    .start(start), .start_sel(start_sel), .start_addr(start_addr),
    .auto_inc(auto_inc), .data_we(data_we), .data_in(data_in),
    .mode(mode), .last(last), .src(src_q[HB_W-1:0]),
    .vr_rdata(vr_rdata), .hb_ack(hb_ack), .hb_data(hb_data),
    .busy(busy), .unit_done(unit_done),
    .vr_re(vr_re), .vr_addr(vr_addr),
    .hb_req(hb_req), .hb_addr(hb_addr),
    .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_byte(mem_byte)
  );

  AST_WRITE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_we |-> busy); // R9

  AST_DONE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(busy) |-> (cnt_q == '0)); // R10

endmodule

// File: tb/vram_dma_engine_test.sv
module vram_dma_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_wdata;
  logic        start;
  logic [1:0]  start_sel;
  logic [15:0] start_addr;
  logic [7:0]  auto_inc;
  logic        data_we;
  logic [15:0] data_in;
  logic        busy;
  logic [15:0] cnt_q;
  logic [23:0] src_q;
  logic        vr_re;
  logic [15:0] vr_addr;
  logic [7:0]  vr_rdata;
  logic        hb_req;
  logic [22:0] hb_addr;
  logic        hb_ack;
  logic [15:0] hb_data;
  logic        mem_we;
  logic [1:0]  mem_sel;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_byte;

  always #2 clk = ~clk;

  vram_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .start(start), .start_sel(start_sel), .start_addr(start_addr), .auto_inc(auto_inc),
    .data_we(data_we), .data_in(data_in), .busy(busy), .cnt_q(cnt_q), .src_q(src_q),
    .vr_re(vr_re), .vr_addr(vr_addr), .vr_rdata(vr_rdata),
    .hb_req(hb_req), .hb_addr(hb_addr), .hb_ack(hb_ack), .hb_data(hb_data),
    .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_byte(mem_byte)
  );

  int          n_run = 0;
  int          n_fail = 0;
  logic [34:0] exp_q[$];
  bit          allow_wr = 1'b0;
  bit          last_seen = 1'b0;
  string       cur_req = "R3";

  function automatic logic [15:0] host_word(logic [22:0] a);
    return {a[7:0], a[15:8]} ^ {9'b0, a[22:16]} ^ 16'h1357;
  endfunction

  function automatic logic [7:0] vram_byte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h6B;
  endfunction

  task automatic check(string req, string what, logic [34:0] act, logic [34:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // external memory models
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_ack   <= 1'b0;
      hb_data  <= '0;
      vr_rdata <= '0;
    end else begin
      hb_ack  <= hb_req && !hb_ack;
      hb_data <= host_word(hb_addr);
      if (vr_re) vr_rdata <= vram_byte(vr_addr);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (last_seen) begin
        check("R9", "busy after last write", {34'b0, busy}, 35'd0);
        last_seen = 1'b0;
      end
      if (mem_we) begin
        if (!allow_wr) check("R3", "write before data", 35'd1, 35'd0);
        else if (exp_q.size() == 0) check("R8", "extra write", 35'd1, 35'd0);
        else begin
          logic [34:0] item;
          item = exp_q.pop_front();
          check(cur_req, "write", {mem_sel, mem_byte, mem_addr, mem_wdata}, item);
          check("R9", "busy during write", {34'b0, busy}, 35'd1);
          if (exp_q.size() == 0) last_seen = 1'b1;
        end
      end
    end
  end

  task automatic reg_write(logic [4:0] idx, logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic start_op(logic [1:0] sel, logic [15:0] addr);
    @(negedge clk);
    start = 1'b1; start_sel = sel; start_addr = addr;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic data_write(logic [15:0] d);
    @(negedge clk);
    data_we = 1'b1; data_in = d;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic push(logic [1:0] sel, logic byt, logic [15:0] addr, logic [15:0] d);
    exp_q.push_back({sel, byt, addr, d});
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
    start = 1'b0; start_sel = '0; start_addr = '0; auto_inc = 8'd1;
    data_we = 1'b0; data_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "busy", {34'b0, busy}, 35'd0);
    check("R1", "mem_we", {34'b0, mem_we}, 35'd0);
    check("R1", "hb_req", {34'b0, hb_req}, 35'd0);
    check("R1", "vr_re", {34'b0, vr_re}, 35'd0);
    check("R1", "cnt_q", {19'b0, cnt_q}, 35'd0);
    check("R1", "src_q", {11'b0, src_q}, 35'd0);

    // R3 fill with wait for data, R11 writes ignored while busy
    reg_write(5'd19, 8'd4); reg_write(5'd20, 8'd0); reg_write(5'd23, 8'h80);
    check("R2", "count readback", {19'b0, cnt_q}, 35'd4);
    cur_req = "R3";
    auto_inc = 8'd1;
    for (int i = 0; i < 4; i++) push(2'd0, 1'b1, 16'h0100 + 16'(i), 16'hAA3C);
    start_op(2'd0, 16'h0100);
    repeat (4) @(negedge clk);
    check("R9", "busy in fill wait", {34'b0, busy}, 35'd1);
    reg_write(5'd19, 8'h09);
    reg_write(5'd21, 8'h77);
    check("R11", "count frozen", {19'b0, cnt_q}, 35'd4);
    check("R11", "source frozen", {11'b0, src_q}, 35'h800000);
    allow_wr = 1'b1;
    data_write(16'hAA3C);
    wait_idle();
    check("R8", "fill writes drained", 35'(exp_q.size()), 35'd0);
    check("R10", "fill count zero", {19'b0, cnt_q}, 35'd0);
    check("R10", "fill source unchanged", {11'b0, src_q}, 35'h800000);
    allow_wr = 1'b0;

    // R4 copy inside VRAM, forced VRAM target
    reg_write(5'd19, 8'd3); reg_write(5'd21, 8'h34); reg_write(5'd22, 8'h12);
    reg_write(5'd23, 8'hC0);
    cur_req = "R4";
    for (int i = 0; i < 3; i++) begin
      logic [7:0] b;
      b = vram_byte(16'h1234 + 16'(i));
      push(2'd0, 1'b1, 16'h2000 + 16'(i), {b, b});
    end
    allow_wr = 1'b1;
    start_op(2'd1, 16'h2000);
    wait_idle();
    check("R4", "copy writes drained", 35'(exp_q.size()), 35'd0);
    check("R10", "copy source advanced", {11'b0, src_q}, 35'hC01237);
    check("R10", "copy count zero", {19'b0, cnt_q}, 35'd0);
    allow_wr = 1'b0;

    // R5/R6/R7 external transfer crossing the 17-bit wrap, bit 22 as address (R2)
    reg_write(5'd19, 8'd3); reg_write(5'd21, 8'hFE); reg_write(5'd22, 8'hFF);
    reg_write(5'd23, 8'h47);
    cur_req = "R6";
    auto_inc = 8'd2;
    push(2'd1, 1'b0, 16'h0040, host_word(23'h47FFFE));
    push(2'd1, 1'b0, 16'h0042, host_word(23'h47FFFF));
    push(2'd1, 1'b0, 16'h0044, host_word(23'h460000));
    allow_wr = 1'b1;
    start_op(2'd1, 16'h0040);
    wait_idle();
    check("R5", "external writes drained", 35'(exp_q.size()), 35'd0);
    check("R6", "wrapped source", {11'b0, src_q}, 35'h460001);
    allow_wr = 1'b0;

    // R7 destination step with wrap at 16 bits
    reg_write(5'd19, 8'd2); reg_write(5'd21, 8'h10); reg_write(5'd22, 8'h00);
    reg_write(5'd23, 8'h00);
    cur_req = "R7";
    auto_inc = 8'h80;
    push(2'd2, 1'b0, 16'hFFC0, host_word(23'h000010));
    push(2'd2, 1'b0, 16'h0040, host_word(23'h000011));
    allow_wr = 1'b1;
    start_op(2'd2, 16'hFFC0);
    wait_idle();
    check("R7", "step writes drained", 35'(exp_q.size()), 35'd0);
    allow_wr = 1'b0;

    // R8 zero count means 65536 units
    reg_write(5'd19, 8'd0); reg_write(5'd20, 8'd0); reg_write(5'd23, 8'h80);
    cur_req = "R8";
    auto_inc = 8'd1;
    for (int i = 0; i < 65536; i++) push(2'd0, 1'b1, 16'(i), 16'h0055);
    start_op(2'd0, 16'h0000);
    allow_wr = 1'b1;
    data_write(16'h0055);
    wait_idle();
    check("R8", "65536 writes drained", 35'(exp_q.size()), 35'd0);
    check("R10", "count zero after long fill", {19'b0, cnt_q}, 35'd0);
    allow_wr = 1'b0;
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule